// File: doc/BRIEF.md
# Serial Word Master with Per-Select Timing

This block is a register-mapped master for a three-wire serial bus: one clock out, one data out, one data in, plus four chip-select lines. Software loads a transmit word, then issues a single command. That command gives the select index, how many bits go out and how many bits come back, and whether the select should stay asserted afterwards. The controller clocks the outbound bits first, MSB first, and then clocks in the inbound bits. The received word is right-justified in the data register, and a ready flag tells software to collect it.

Each of the four selects carries its own six-bit setting: the edge on which output changes, the edge on which input is sampled, the active level of the select, a clock divider, and an optional wait for the slave to pull the input low before any clock. A global setup word enables the controller and adds a prescaler. Another word fixes the level the serial clock rests at between transfers. Because the select can stay asserted from one command to the next, frames longer than one word are built from several commands.

Top module: `uwire_master`

## Requirements
- R1: Registers sit at word addresses 0 (data: a write loads transmit, a read returns receive), 1 (command/status), 2 and 3 (select settings, 12 bits each), 4 (bit 0 enable, bits 2:1 prescale) and 5 (bit 0 clock idle level). They read back what was written, and address 6 reads zero. After reset everything reads zero.
- R2: A command write with bit 13 set, while idle and enabled, with a nonzero total count, sets busy (status bit 14). The transfer then runs exactly write-count plus read-count clock pulses, two serial clock edges each, after which busy clears.
- R3: The write count sits in command bits 9:5. Outbound bits are taken from the top of the transmit word, MSB first. A count above 16 is treated as 16.
- R4: The read count sits in command bits 4:0, also clamped to 16. Inbound bits are shifted in so the last one lands in bit 0, upper bits zero. Status bit 15 sets when the last bit is captured and clears when address 0 is read.
- R5: Every outbound bit is clocked before the first inbound bit is sampled.
- R6: In a select's setting, bit 1 set means output changes on rising edges, and bit 0 set means input is sampled on rising edges. Clear means falling in both cases. The slave-facing sampling edge is the opposite of the drive edge.
- R7: The serial clock rests at the level of address 5 bit 0 whenever no transfer runs.
- R8: The serial clock half-period is 2^(prescale + d) system cycles, where d is 0, 1 or 2 from setting bits 4:3 (codes 0, 1, 2; code 3 acts as 2).
- R9: Command bits 11:10 pick the select and bit 12 asserts it. The select is active during a transfer and stays active afterwards while bit 12 is set. A command with bit 12 clear releases it. Setting bit 2 makes the line active high; otherwise it is active low, and unselected lines sit at their inactive level.
- R10: A command write while busy is ignored entirely.
- R11: With setting bit 5 set, no clock edge occurs until the data input is low.
- R12: A start is ignored while address 4 bit 0 is clear. Clearing it during a transfer aborts the transfer at once.
- R13: Select 0 and select 1 settings are bits 5:0 and 11:6 of address 2. Select 2 and select 3 settings use the same positions in address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (matters for address 0) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Serial data to slave |
| ser_in | input | 1 | Serial data from slave |
| sel_o | output | 4 | Chip-select lines, per-select polarity |

## Verification
A stuck shift register or a wrong pulse counter shows within one transfer: the slave model captures a different word, or it counts a different number of clock edges before busy clears. An edge-selection fault corrupts the first or last bit, because the slave samples on the opposite edge. A divider fault shows in the very first measured half-period. A corrupt command latch, such as one altered by a write during busy, appears at the status readback right after the transfer ends. Select-hold faults appear on the select pins in the cycle after busy falls.

// File: rtl/uwire_master.sv
`timescale 1ns/1ps
module uwire_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        ser_clk,
  output logic        ser_out,
  input  logic        ser_in,
  output logic [3:0]  sel_o
);

  logic [15:0] tx_q, tx_sh, rx_q;
  logic        rx_rdy, busy, wait_rdy, sclk_q, cs_hold, idle_hi, en;
  logic [1:0]  cs_idx, pre;
  logic [4:0]  wcnt, rcnt;
  logic [11:0] sr1, sr2;
  logic [5:0]  div_cnt, pulse;
  logic [3:0]  act;

  function automatic logic [5:0] cfg_of(input logic [1:0] i, input logic [11:0] a, input logic [11:0] b);
    case (i)
      2'd0: return a[5:0];
      2'd1: return a[11:6];
      2'd2: return b[5:0];
      default: return b[11:6];
    endcase
  endfunction

  function automatic logic [5:0] clamp16(input logic [4:0] n);
    return (n > 5'd16) ? 6'd16 : {1'b0, n};
  endfunction

  wire [5:0] cfg     = cfg_of(cs_idx, sr1, sr2);
  wire [2:0] dsel    = (cfg[4:3] == 2'd0) ? 3'd0 : (cfg[4:3] == 2'd1) ? 3'd1 : 3'd2;
  wire [2:0] shamt   = {1'b0, pre} + dsel;
  wire [5:0] half_m1 = (6'd1 << shamt) - 6'd1;
  wire [5:0] wc      = clamp16(wcnt);
  wire [5:0] total   = wc + clamp16(rcnt);
  wire [5:0] n_total = clamp16(bus_wdata[9:5]) + clamp16(bus_wdata[4:0]);
  wire       n_chk   = bus_wdata[11] ? (bus_wdata[10] ? sr2[11] : sr2[5])
                                     : (bus_wdata[10] ? sr1[11] : sr1[5]);
  wire       tick    = busy && !wait_rdy && (div_cnt == half_m1);
  wire       rise    = !sclk_q;
  wire       lead    = (sclk_q == idle_hi);
  wire       in_wr   = pulse < wc;
  wire       last    = (pulse + 6'd1 == total);

  assign ser_out = tx_sh[15];
  assign ser_clk = busy ? sclk_q : idle_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0; tx_sh <= '0; rx_q <= '0; rx_rdy <= 1'b0; busy <= 1'b0;
      wait_rdy <= 1'b0; sclk_q <= 1'b0; cs_hold <= 1'b0; idle_hi <= 1'b0;
      en <= 1'b0; cs_idx <= '0; pre <= '0; wcnt <= '0; rcnt <= '0;
      sr1 <= '0; sr2 <= '0; div_cnt <= '0; pulse <= '0;
    end else begin
      if (bus_rd && bus_addr == 3'd0) rx_rdy <= 1'b0;
      if (busy && wait_rdy && !ser_in) wait_rdy <= 1'b0;
      if (tick) begin
        div_cnt <= '0;
        sclk_q  <= ~sclk_q;
        if (in_wr && (rise == cfg[1]) && !(lead && pulse == 6'd0))
          tx_sh <= {tx_sh[14:0], 1'b0};
        if (!in_wr && (rise == cfg[0])) begin
          rx_q <= {rx_q[14:0], ser_in};
          if (last) rx_rdy <= 1'b1;
        end
        if (!lead) begin
          pulse <= pulse + 6'd1;
          if (last) busy <= 1'b0;
        end
      end else if (busy && !wait_rdy) begin
        div_cnt <= div_cnt + 6'd1;
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: tx_q <= bus_wdata;
          3'd1: if (!busy) begin
            cs_idx  <= bus_wdata[11:10];
            cs_hold <= bus_wdata[12];
            wcnt    <= bus_wdata[9:5];
            rcnt    <= bus_wdata[4:0];
            if (bus_wdata[13] && en && n_total != 6'd0) begin
              busy     <= 1'b1;
              wait_rdy <= n_chk;
              tx_sh    <= tx_q;
              rx_q     <= '0;
              rx_rdy   <= 1'b0;
              div_cnt  <= '0;
              pulse    <= '0;
              sclk_q   <= idle_hi;
            end
          end
          3'd2: sr1 <= bus_wdata[11:0];
          3'd3: sr2 <= bus_wdata[11:0];
          3'd4: begin
            en  <= bus_wdata[0];
            pre <= bus_wdata[2:1];
            if (!bus_wdata[0]) busy <= 1'b0;
          end
          3'd5: idle_hi <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = rx_q;
      3'd1:    bus_rdata = {rx_rdy, busy, 1'b0, cs_hold, cs_idx, wcnt, rcnt};
      3'd2:    bus_rdata = {4'd0, sr1};
      3'd3:    bus_rdata = {4'd0, sr2};
      3'd4:    bus_rdata = {13'd0, pre, en};
      3'd5:    bus_rdata = {15'd0, idle_hi};
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      act[i]   = (cs_idx == 2'(i)) && (cs_hold || busy);
      sel_o[i] = ~(act[i] ^ cfg_of(2'(i), sr1, sr2)[2]);
    end
  end

  assert_hold_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && cs_hold |-> sel_o[cs_idx] == cfg[2]);

  assert_cmd_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cs_idx) && $stable(wcnt) && $stable(rcnt));

  assert_rdy_from_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(busy));

  assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pulse < total);

  assert_wait_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wait_rdy |=> $stable(ser_clk));

  assert_wait_needs_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wait_rdy |-> cfg[5]);

endmodule

// File: tb/uwire_master_tb_top.sv
`timescale 1ns/1ps
module uwire_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, bwr = 1'b0, brd = 1'b0;
  logic [2:0]  baddr = '0;
  logic [15:0] bwd = '0;
  wire  [15:0] brdata;
  wire         sclk, sdo, sdi;
  wire  [3:0]  sel;

  int nvec = 0, nfail = 0;
  int cyc = 0;
  int xfer_id = 0, seen_id = 0;
  int m_w = 0, m_r = 0;
  bit m_drv = 0, m_smp = 0, m_idle = 0, hold_hi = 0;
  logic [15:0] rpat = '0;
  int pidx = 0, ridx = 0, ncap = 0, nedges = 0, e1 = 0, first_gap = 0, w_at_rd = -1;
  logic [15:0] cap = '0;
  logic prev_sclk = 1'b0;

  assign sdi = hold_hi | ((ridx < m_r) ? rpat[m_r-1-ridx] : 1'b0);

  uwire_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_rd(brd), .bus_addr(baddr),
    .bus_wdata(bwd), .bus_rdata(brdata), .ser_clk(sclk), .ser_out(sdo),
    .ser_in(sdi), .sel_o(sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (seen_id != xfer_id) begin
      seen_id = xfer_id; pidx = 0; ridx = 0; ncap = 0; nedges = 0;
      e1 = 0; first_gap = 0; cap = '0; w_at_rd = -1;
    end else if (sclk !== prev_sclk) begin
      nedges++;
      if (nedges == 1) e1 = cyc;
      if (nedges == 2) first_gap = cyc - e1;
      if (pidx < m_w) begin
        if (sclk != m_drv) begin cap = {cap[14:0], sdo}; ncap++; end
      end else if (pidx < m_w + m_r && sclk == m_smp) begin
        if (ridx == 0) w_at_rd = ncap;
        ridx++;
      end
      if (prev_sclk != m_idle) pidx++;
    end
    prev_sclk = sclk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); baddr = a; bwd = d; bwr = 1'b1;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); baddr = a; brd = 1'b1;
    #1 d = brdata;
    @(negedge clk); brd = 1'b0;
  endtask

  function automatic logic [15:0] mkcmd(input bit st, input bit hd, input int idx, input int w, input int r);
    return {2'b00, st, hd, idx[1:0], w[4:0], r[4:0]};
  endfunction

  task automatic wait_idle();
    logic [15:0] s;
    int g = 0;
    s = 16'h4000;
    while (s[14] && g < 5000) begin bus_read(3'd1, s); g++; end
  endtask

  task automatic kick(input int idx, input int w, input int r, input logic [15:0] tx,
                      input logic [15:0] pat, input bit hd, input bit drv, input bit smp, input bit idl);
    m_w = (w > 16) ? 16 : w; m_r = (r > 16) ? 16 : r;
    m_drv = drv; m_smp = smp; m_idle = idl; rpat = pat;
    bus_write(3'd0, tx);
    xfer_id++;
    bus_write(3'd1, mkcmd(1'b1, hd, idx, w, r));
  endtask

  task automatic run(input int idx, input int w, input int r, input logic [15:0] tx,
                     input logic [15:0] pat, input bit hd, input bit drv, input bit smp, input bit idl);
    kick(idx, w, r, tx, pat, hd, drv, smp, idl);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_read(3'd1, d); chk("R1 status after reset", d, 0);
    bus_read(3'd0, d); chk("R1 data after reset", d, 0);
    chk("R7 clock idle after reset", sclk, 0);
    chk("R9 selects inactive after reset", sel, 4'hF);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    bus_write(3'd2, 16'hFFAB); bus_read(3'd2, d); chk("R13 settings word A", d, 16'h0FAB);
    bus_write(3'd3, 16'h0765); bus_read(3'd3, d); chk("R13 settings word B", d, 16'h0765);
    bus_write(3'd4, 16'h0007); bus_read(3'd4, d); chk("R1 enable/prescale", d, 7);
    bus_write(3'd5, 16'h0001); bus_read(3'd5, d); chk("R1 idle level reg", d, 1);
    bus_write(3'd6, 16'hFFFF); bus_read(3'd6, d); chk("R1 address 6 reads zero", d, 0);
    bus_write(3'd5, 0); bus_write(3'd2, 0); bus_write(3'd3, 0); bus_write(3'd4, 1);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    run(0, 8, 0, 16'hA5FF, 0, 0, 0, 0, 0);
    chk("R3 eight bits out MSB first", cap, 16'h00A5);
    chk("R2 edge count", nedges, 16);
    chk("R8 half period div2 pre0", first_gap, 1);
    bus_read(3'd1, d); chk("R2 busy cleared", d[14], 0);
    chk("R7 clock back at idle", sclk, 0);
    run(0, 31, 0, 16'h1234, 0, 0, 0, 0, 0);
    chk("R3 count clamped to 16 word", cap, 16'h1234);
    chk("R3 count clamped to 16 edges", nedges, 32);
  endtask

  task automatic t_read();
    logic [15:0] d;
    run(0, 0, 12, 16'h0, 16'h0B3C, 0, 0, 0, 0);
    bus_read(3'd1, d); chk("R4 ready flag set", d[15], 1);
    bus_read(3'd0, d); chk("R4 received word right-justified", d, 16'h0B3C);
    bus_read(3'd1, d); chk("R4 ready flag cleared by read", d[15], 0);
  endtask

  task automatic t_wr_rd();
    logic [15:0] d;
    run(0, 4, 5, 16'h9000, 16'h0015, 0, 0, 0, 0);
    chk("R5 write part", cap, 16'h0009);
    chk("R5 all writes before first read", w_at_rd, 4);
    bus_read(3'd0, d); chk("R5 read part", d, 16'h0015);
  endtask

  task automatic t_edges();
    logic [15:0] d;
    bus_write(3'd2, 16'h00C0);
    bus_write(3'd5, 16'h0001);
    chk("R7 idle high level", sclk, 1);
    run(1, 16, 16, 16'h6E19, 16'hF00D, 0, 1, 1, 1);
    chk("R6 rising drive, idle high, out", cap, 16'h6E19);
    bus_read(3'd0, d); chk("R6 rising sample, idle high, in", d, 16'hF00D);
    chk("R7 clock rests high after transfer", sclk, 1);
    bus_write(3'd5, 16'h0000);
    bus_write(3'd2, 16'h0080);
    run(1, 8, 8, 16'hC300, 16'h005A, 0, 1, 0, 0);
    chk("R6 rising drive, falling sample, out", cap, 16'h00C3);
    bus_read(3'd0, d); chk("R6 rising drive, falling sample, in", d, 16'h005A);
    bus_write(3'd2, 0);
  endtask

  task automatic t_div();
    bus_write(3'd3, 16'h0010); bus_write(3'd4, 16'h0003);
    run(2, 2, 0, 16'h4000, 0, 0, 0, 0, 0);
    chk("R8 half period 8", first_gap, 8);
    bus_write(3'd3, 16'h0008); bus_write(3'd4, 16'h0001);
    run(2, 2, 0, 16'h4000, 0, 0, 0, 0, 0);
    chk("R8 half period 2", first_gap, 2);
    bus_write(3'd3, 0);
  endtask

  task automatic t_cs();
    bus_write(3'd3, 16'h0100);
    chk("R9 active-high line idle low", sel, 4'h7);
    run(3, 4, 0, 16'hF000, 0, 1, 0, 0, 0);
    chk("R9 select held after transfer", sel, 4'hF);
    bus_write(3'd1, mkcmd(0, 0, 3, 0, 0));
    chk("R9 select released", sel, 4'h7);
    bus_write(3'd1, mkcmd(0, 1, 0, 0, 0));
    chk("R9 active-low select asserted", sel, 4'h6);
    bus_write(3'd1, mkcmd(0, 0, 0, 0, 0));
    chk("R9 active-low select released", sel, 4'h7);
    bus_write(3'd3, 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] d;
    bus_write(3'd2, 16'h0010); bus_write(3'd4, 16'h0007);
    kick(0, 4, 0, 16'h5000, 0, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    bus_read(3'd1, d); chk("R10 busy during transfer", d[14], 1);
    bus_write(3'd1, mkcmd(1, 1, 1, 8, 0));
    wait_idle();
    bus_read(3'd1, d); chk("R10 command unchanged", d, 16'h0080);
    chk("R10 only first transfer ran", nedges, 8);
    chk("R10 no select held", sel, 4'hF);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    kick(0, 16, 0, 16'hFFFF, 0, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    bus_write(3'd4, 16'h0000);
    bus_read(3'd1, d); chk("R12 abort clears busy", d[14], 0);
    chk("R12 clock idle after abort", sclk, 0);
    kick(0, 4, 0, 16'hFFFF, 0, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    bus_read(3'd1, d); chk("R12 start ignored when disabled", d[14], 0);
    chk("R12 no edges when disabled", nedges, 0);
    bus_write(3'd4, 16'h0001); bus_write(3'd2, 0);
  endtask

  task automatic t_ready();
    logic [15:0] d;
    bus_write(3'd2, 16'h0020);
    hold_hi = 1;
    kick(0, 4, 0, 16'hA000, 0, 0, 0, 0, 0);
    repeat (40) @(negedge clk);
    bus_read(3'd1, d); chk("R11 waiting keeps busy", d[14], 1);
    chk("R11 no edges while input high", nedges, 0);
    hold_hi = 0;
    wait_idle();
    chk("R11 transfer after input low", cap, 16'h000A);
    bus_write(3'd2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_basic();
    t_read();
    t_wr_rd();
    t_edges();
    t_div();
    t_cs();
    t_busy_ignore();
    t_enable();
    t_ready();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule